// File: doc/BRIEF.md
# Programmable GPIO Port Controller

This block gives software control over a bank of 1 to 32 general-purpose pins through a 32-bit APB slave. Every pin is programmed on its own to act as an input, an output driven from a data register, or a bypass pin whose output comes from an auxiliary on-chip peripheral signal. A per-pin output enable is presented at the pad edge, so three-state or open-drain pad cells can sit outside the block.

Output bits can be changed as a whole word, or one bit or any group at a time through dedicated set and clear locations. These leave untouched bits alone, so no read-modify-write is needed. Pin levels are sampled into an input register. A control bit selects whether sampling runs on the system clock or on an external sampling clock. Samples taken on the external clock cross into the system clock domain through a two-flop synchronizer before software can read them.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the output data, output enable, auxiliary select and control registers are all zero, so `pad_oe` and `pad_out` are zero.
- R2: A write to offset 0x04 (output data), 0x08 (output enable) or 0x0C (auxiliary select) stores `pwdata[PINS-1:0]`. A read of the same offset returns that value zero-extended to 32 bits. Offset 0x18 (control) keeps only bit 0, the sampling clock select.
- R3: A write to offset 0x10 sets every output data bit whose `pwdata` bit is 1 and leaves the bits written with 0 unchanged. A read of 0x10 returns zero.
- R4: A write to offset 0x14 clears every output data bit whose `pwdata` bit is 1 and leaves the bits written with 0 unchanged. A read of 0x14 returns zero.
- R5: For each pin, `pad_out` equals `aux_in` when that pin's auxiliary select bit is 1. Otherwise it equals the output data bit.
- R6: `pad_oe` equals the output enable register bit for bit. A 1 drives the pin and a 0 leaves it as an input.
- R7: With control bit 0 at 0, a level held on `pin_in` is returned by a read of offset 0x00 no later than three system clocks after it is applied.
- R8: With control bit 0 at 1, offset 0x00 returns the `pin_in` value captured at the last rising edge of `ext_clk`, visible three system clocks after that edge. Later pin changes without an `ext_clk` edge do not alter it.
- R9: Reads of any unmapped offset return zero. Writes to offset 0x00 or to unmapped offsets change no register.
- R10: `pready` is always 1 and `pslverr` is always 0.
- R11: Registers change only on a write access phase (`psel`, `penable` and `pwrite` all high). A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Transfer error, always 0 |
| ext_clk | input | 1 | External clock for input sampling |
| pin_in | input | PINS | Levels seen at the pads |
| aux_in | input | PINS | Auxiliary peripheral outputs for bypass |
| pad_out | output | PINS | Output level to the pads |
| pad_oe | output | PINS | Per-pin output enable to the pads |

## Verification
The bench aims at the places where a GPIO register file usually goes wrong. A set or clear that touched the bits written as 0 would show up as pad outputs diverging from the reference on the next clock. A pad mux with a swapped select would drive data-register values on bypassed pins, or the reverse. The external sampling path is checked for capture on the `ext_clk` edge only. A design that followed `pin_in` live, or read the system-clock sample, would report a changed level without an edge. Setup-only phases, writes to the read-only input offset and unmapped accesses are mixed in, so a decoder that ignored `penable` or matched on partial address bits would corrupt the register state that the per-clock comparison watches.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Byte offsets of the register bank
  localparam int OFF_IN   = 'h00;
  localparam int OFF_OUT  = 'h04;
  localparam int OFF_OE   = 'h08;
  localparam int OFF_AUX  = 'h0C;
  localparam int OFF_SET  = 'h10;
  localparam int OFF_CLR  = 'h14;
  localparam int OFF_CTRL = 'h18;

  localparam int BUS_W = 32;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int PINS   = 8,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [gpio_pkg::BUS_W-1:0] wdata,
  input  logic [PINS-1:0]          in_val,
  output logic [PINS-1:0]          out_q,
  output logic [PINS-1:0]          oe_q,
  output logic [PINS-1:0]          aux_q,
  output logic                     ext_sel_q,
  output logic [gpio_pkg::BUS_W-1:0] rdata
);
  import gpio_pkg::*;

  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFF_IN);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFF_OUT);
  localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(OFF_OE);
  localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(OFF_AUX);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic [PINS-1:0] wbits;
  logic [PINS-1:0] out_d, oe_d, aux_d;
  logic            ext_sel_d;
  logic            out_en, oe_en, aux_en, ctrl_en;

  assign wbits = wdata[PINS-1:0];

  // Next-state logic with explicit clock enables
  always_comb begin
    out_en    = 1'b0;
    oe_en     = wr_en && (addr == A_OE);
    aux_en    = wr_en && (addr == A_AUX);
    ctrl_en   = wr_en && (addr == A_CTRL);
    out_d     = out_q;
    oe_d      = wbits;
    aux_d     = wbits;
    ext_sel_d = wdata[0];
    if (wr_en) begin
      if (addr == A_OUT) begin
        out_en = 1'b1;
        out_d  = wbits;
      end else if (addr == A_SET) begin
        out_en = 1'b1;
        out_d  = out_q | wbits;
      end else if (addr == A_CLR) begin
        out_en = 1'b1;
        out_d  = out_q & ~wbits;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      oe_q      <= '0;
      aux_q     <= '0;
      ext_sel_q <= 1'b0;
    end else begin
      if (out_en)  out_q     <= out_d;
      if (oe_en)   oe_q      <= oe_d;
      if (aux_en)  aux_q     <= aux_d;
      if (ctrl_en) ext_sel_q <= ext_sel_d;
    end
  end

  // Read mux: write-only and unmapped offsets return zero
  always_comb begin
    rdata = '0;
    case (addr)
      A_IN:    rdata = BUS_W'(in_val);
      A_OUT:   rdata = BUS_W'(out_q);
      A_OE:    rdata = BUS_W'(oe_q);
      A_AUX:   rdata = BUS_W'(aux_q);
      A_CTRL:  rdata = BUS_W'(ext_sel_q);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_insample.sv
module gpio_insample #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_clk,
  input  logic            ext_sel,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] in_val
);
  logic [PINS-1:0] sys_s1, sys_s2;
  logic [PINS-1:0] ext_cap;
  logic [PINS-1:0] ext_s1, ext_s2;

  // Capture in the external clock domain
  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) ext_cap <= '0;
    else        ext_cap <= pin_in;
  end

  // Two-flop synchronizers into the system clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_s1 <= '0;
      sys_s2 <= '0;
      ext_s1 <= '0;
      ext_s2 <= '0;
    end else begin
      sys_s1 <= pin_in;
      sys_s2 <= sys_s1;
      ext_s1 <= ext_cap;
      ext_s2 <= ext_s1;
    end
  end

  assign in_val = ext_sel ? ext_s2 : sys_s2;
endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux #(
  parameter int PINS = 8
) (
  input  logic [PINS-1:0] out_q,
  input  logic [PINS-1:0] aux_q,
  input  logic [PINS-1:0] aux_in,
  output logic [PINS-1:0] pad_out
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign pad_out[i] = aux_q[i] ? aux_in[i] : out_q[i];
  end
endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl #(
  parameter int PINS   = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              ext_clk,
  input  logic [PINS-1:0]   pin_in,
  input  logic [PINS-1:0]   aux_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  logic            wr_en;
  logic [PINS-1:0] out_q, oe_q, aux_q, in_val;
  logic            ext_sel_q;

  assign wr_en   = psel && penable && pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign pad_oe  = oe_q;

  gpio_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(paddr), .wdata(pwdata),
    .in_val(in_val), .out_q(out_q), .oe_q(oe_q), .aux_q(aux_q),
    .ext_sel_q(ext_sel_q), .rdata(prdata)
  );

  gpio_insample #(.PINS(PINS)) u_insample (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_sel(ext_sel_q),
    .pin_in(pin_in), .in_val(in_val)
  );

  gpio_padmux #(.PINS(PINS)) u_padmux (
    .out_q(out_q), .aux_q(aux_q), .aux_in(aux_in), .pad_out(pad_out)
  );
endmodule

// File: rtl/gpio_apb_checker.sv
module gpio_apb_checker #(
  parameter int PINS   = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic              pready,
  input logic              pslverr,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   out_q,
  input logic [PINS-1:0]   oe_q,
  input logic [PINS-1:0]   aux_q
);
  logic            wr;
  logic [PINS-1:0] wmask;
  assign wr    = psel && penable && pwrite;
  assign wmask = pwdata[PINS-1:0];

  // R10: zero-wait, error-free transfers
  always @(posedge clk)
    assert_ready_R10: assert (pready === 1'b1 && pslverr === 1'b0);

  // R1: pads quiet during reset
  always @(posedge clk)
    if (!rst_n) assert_reset_R1: assert (pad_oe == '0 && pad_out == '0);

  // R3: set touches only the bits written as 1
  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == ADDR_W'(gpio_pkg::OFF_SET)) |=>
      ((out_q & $past(wmask)) == $past(wmask)) &&
      ((out_q & ~$past(wmask)) == ($past(out_q) & ~$past(wmask))));

  // R4: clear touches only the bits written as 1
  assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == ADDR_W'(gpio_pkg::OFF_CLR)) |=>
      ((out_q & $past(wmask)) == '0) &&
      ((out_q & ~$past(wmask)) == ($past(out_q) & ~$past(wmask))));

  // R11: no write access phase, no state change
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(out_q) && $stable(oe_q) && $stable(aux_q));
endmodule

bind gpio_apb_ctrl gpio_apb_checker #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pready(pready), .pslverr(pslverr),
  .pad_out(pad_out), .pad_oe(pad_oe), .out_q(out_q), .oe_q(oe_q), .aux_q(aux_q)
);

// File: tb/tb_gpio_apb_ctrl.sv
module tb_gpio_apb_ctrl;
  localparam int PINS   = 8;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic              pready, pslverr;
  logic              ext_clk = 1'b0;
  logic [PINS-1:0]   pin_in = '0, aux_in = '0;
  logic [PINS-1:0]   pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [PINS-1:0] m_out = '0, m_oe = '0, m_aux = '0;
  logic            m_ext = 1'b0;

  gpio_apb_ctrl #(.PINS(PINS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .ext_clk(ext_clk), .pin_in(pin_in), .aux_in(aux_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model (R5, R6, R10, R11)
  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      check(pad_out == ((m_aux & aux_in) | (~m_aux & m_out)), "R5/R11 pad_out",
            32'(pad_out), 32'((m_aux & aux_in) | (~m_aux & m_out)));
      check(pad_oe == m_oe, "R6/R11 pad_oe", 32'(pad_oe), 32'(m_oe));
      check(pready === 1'b1 && pslverr === 1'b0, "R10 handshake",
            {30'd0, pready, pslverr}, 32'h2);
    end
  end

  task automatic model_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    case (a)
      8'h04: m_out = d[PINS-1:0];
      8'h08: m_oe  = d[PINS-1:0];
      8'h0C: m_aux = d[PINS-1:0];
      8'h10: m_out = m_out | d[PINS-1:0];
      8'h14: m_out = m_out & ~d[PINS-1:0];
      8'h18: m_ext = d[0];
      default: ;
    endcase
  endtask

  task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(posedge clk);
    #1 model_write(a, d);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic read_check(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                            input string req);
    logic [31:0] d;
    apb_read(a, d);
    check(d === exp, req, d, exp);
  endtask

  task automatic ext_pulse();
    #2 ext_clk = 1'b1;
    #3 ext_clk = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pad_oe == '0 && pad_out == '0, "R1 pads in reset", 32'({pad_oe, pad_out}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_check(8'h04, 32'h0, "R1 out after reset");
    read_check(8'h08, 32'h0, "R1 oe after reset");
    read_check(8'h0C, 32'h0, "R1 aux after reset");
    read_check(8'h18, 32'h0, "R1 ctrl after reset");

    // R2: register write/read-back, upper bits dropped
    apb_write(8'h04, 32'hFFFF_FFA5);
    read_check(8'h04, 32'h0000_00A5, "R2 out readback");
    apb_write(8'h08, 32'h1234_560F);
    read_check(8'h08, 32'h0000_000F, "R2 oe readback");
    apb_write(8'h18, 32'hFFFF_FFFE);
    read_check(8'h18, 32'h0, "R2 ctrl keeps bit0 only (0)");

    // R3: set
    apb_write(8'h04, 32'h0000_0011);
    apb_write(8'h10, 32'h0000_0006);
    read_check(8'h04, 32'h17, "R3 set bits 1,2");
    apb_write(8'h10, 32'h0000_0010);
    read_check(8'h04, 32'h17, "R3 set already-set bit");
    read_check(8'h10, 32'h0, "R3 set reads zero");

    // R4: clear
    apb_write(8'h14, 32'h0000_0003);
    read_check(8'h04, 32'h14, "R4 clear bits 0,1");
    apb_write(8'h14, 32'h0000_0000);
    read_check(8'h04, 32'h14, "R4 clear with zero mask");
    read_check(8'h14, 32'h0, "R4 clear reads zero");

    // R5/R6: bypass mux and output enable under several patterns
    apb_write(8'h08, 32'hFF);
    apb_write(8'h04, 32'h5A);
    aux_in = 8'hC3;
    apb_write(8'h0C, 32'hF0);
    read_check(8'h0C, 32'hF0, "R2 aux readback");
    @(negedge clk); aux_in = 8'h3C;
    @(negedge clk);
    check(pad_out == 8'h3A, "R5 mixed bypass", 32'(pad_out), 32'h3A);
    apb_write(8'h0C, 32'hFF);
    @(negedge clk);
    check(pad_out == aux_in, "R5 full bypass", 32'(pad_out), 32'(aux_in));
    apb_write(8'h0C, 32'h00);
    apb_write(8'h08, 32'h81);
    @(negedge clk);
    check(pad_out == 8'h5A && pad_oe == 8'h81, "R6 oe pattern",
          32'({pad_oe, pad_out}), 32'h815A);

    // R11: setup phase only, no access phase
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = 8'h04; pwdata = 32'h00; penable = 1'b0;
    repeat (2) @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    read_check(8'h04, 32'h5A, "R11 setup-only write ignored");

    // R9: unmapped and read-only offsets
    apb_write(8'h00, 32'hFF);
    apb_write(8'h1C, 32'hFF);
    apb_write(8'h44, 32'hFF);
    read_check(8'h04, 32'h5A, "R9 out unchanged by stray writes");
    read_check(8'h08, 32'h81, "R9 oe unchanged by stray writes");
    read_check(8'h1C, 32'h0, "R9 unmapped read 0x1C");
    read_check(8'h80, 32'h0, "R9 unmapped read 0x80");

    // R7: system-clock sampling
    pin_in = 8'h96;
    repeat (3) @(posedge clk);
    read_check(8'h00, 32'h96, "R7 sys sample 96");
    pin_in = 8'h01;
    repeat (3) @(posedge clk);
    read_check(8'h00, 32'h01, "R7 sys sample 01");

    // R8: external-clock sampling
    apb_write(8'h18, 32'h1);
    read_check(8'h18, 32'h1, "R2 ctrl bit0 set");
    pin_in = 8'hE7;
    @(negedge clk);
    ext_pulse();
    repeat (3) @(posedge clk);
    read_check(8'h00, 32'hE7, "R8 ext capture E7");
    pin_in = 8'h18;
    repeat (5) @(posedge clk);
    read_check(8'h00, 32'hE7, "R8 no edge, value held");
    @(negedge clk);
    ext_pulse();
    repeat (3) @(posedge clk);
    read_check(8'h00, 32'h18, "R8 ext capture 18");
    apb_write(8'h18, 32'h0);
    pin_in = 8'h77;
    repeat (3) @(posedge clk);
    read_check(8'h00, 32'h77, "R7 back to sys sampling");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule